// File: doc/BRIEF.md
# Load-Level Frequency Transition Sequencer

This block owns the CPU's current performance level, one of four numbered 0 (fastest) to 3 (slowest). Two 32-bit configuration words carry, for every level, a 3-bit clock divider and a 2-bit source selector. The block drives the divider and source of the level now in force. When frequency scaling is switched off, it passes through a pair of static fallback fields instead.

A rate request carries the parent clock rate and the desired rate, both in MHz. The block forms the integer ratio between them and searches the levels for a matching divider. It then moves to the first level that matches.

A jump to the fastest level can arrive while the parent clock is fast and the requested rate is fast as well. In that case the jump is only taken directly when a recorded level-1 settling interval has already run out. Otherwise the block parks at level 1 for a full dwell interval, holding busy high, and only then steps to level 0. This gives the supply voltage time to settle before full speed. Each accepted request ends in exactly one done or error pulse.

Top module: `dvfs_seq`

## Requirements
- R1: After reset, level is 0 and busy, done and err are all low.
- R2: While scaling is enabled, act_div and act_src show the fields of the active level. Level 0 uses the upper half (bits 31:16) of cfg_lo_pair and level 1 its lower half. Levels 2 and 3 use the upper and lower halves of cfg_hi_pair. Inside each half, the divider sits at bits 15:13 and the source at bits 10:9.
- R3: While scale_en is low, act_div and act_src equal static_div and static_src. Any request is answered with err, and the level stays unchanged.
- R4: The target ratio is floor(parent_mhz / target_mhz). The first level, searching upward from 0, whose divider equals the ratio is chosen.
- R5: A request fails with err and leaves the level unchanged in three cases: no level matches, target_mhz is 0, or the ratio is 0.
- R6: A request for the level already in force gives done and changes nothing.
- R7: With parent_mhz below FAST_MHZ, the matched level is applied directly, with done one cycle after acceptance and no dwell.
- R8: A move to level 0 can occur with parent and target both at or above FAST_MHZ while no elapsed level-1 interval is recorded. The block then shows level 1 with busy high for exactly DWELL_MS*CYC_PER_MS cycles, and then shows level 0 together with done.
- R9: With a fast parent, entering level 1 from level 2 or 3 starts a settling interval of DWELL_MS*CYC_PER_MS cycles. A fast move to level 0 is direct if it is accepted once that many cycles have passed at level 1; an earlier one takes the full dwell.
- R10: With a fast parent, entering level 1 from level 0 records the interval as already elapsed, so a following fast move to level 0 is direct.
- R11: With a fast parent, moving to level 2 or 3 discards any recorded interval. A later fast move from level 1 to level 0 then takes the dwell, unless an interval has been recorded again since.
- R12: With a fast parent and a target below FAST_MHZ, a move to level 0 is direct.
- R13: While busy is high, no new request is accepted. A request held through a dwell yields exactly one done.
- R14: Every accepted request produces exactly one single-cycle pulse, either done or err, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_en | input | 1 | Frequency scaling enable |
| cfg_lo_pair | input | 32 | Settings for levels 0 (upper half) and 1 (lower half) |
| cfg_hi_pair | input | 32 | Settings for levels 2 (upper half) and 3 (lower half) |
| static_div | input | 3 | Divider used while scaling is off |
| static_src | input | 2 | Source used while scaling is off |
| req_valid | input | 1 | Rate request, held until done or err |
| parent_mhz | input | 12 | Parent clock rate in MHz |
| target_mhz | input | 12 | Requested rate in MHz |
| level | output | 2 | Level in force |
| act_div | output | 3 | Divider in force |
| act_src | output | 2 | Source in force |
| busy | output | 1 | Dwell at level 1 in progress |
| done | output | 1 | Request completed |
| err | output | 1 | Request rejected |

## Verification
The bench builds the block with CYC_PER_MS = 4 and DWELL_MS = 20, so each dwell and each settling interval lasts 80 cycles. FAST_MHZ stays at 1000. These values make the interval boundary reachable in a short run: a fast move to level 0 is accepted one cycle before the interval runs out and again exactly when it does, and the first gets a dwell while the second is direct. The 1000 MHz threshold is exercised on both sides, with 1200 MHz and 800 MHz parents and with targets at 900 and 1200 MHz.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
  localparam int LVL_W  = 2;
  localparam int DIV_W  = 3;
  localparam int SRC_W  = 2;
  localparam int HALF_W = 16;
  localparam int DIV_LSB = 13;
  localparam int SRC_LSB = 9;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_DWELL = 1'b1
  } seq_state_t;
endpackage

// File: rtl/dvfs_level_table.sv
module dvfs_level_table
  import dvfs_pkg::*;
#(
  parameter int NUM_LVL = 4,
  parameter int RATIO_W = 12,
  localparam int CFG_W  = NUM_LVL * HALF_W
) (
  input  logic [CFG_W-1:0]   cfg,
  input  lvl_t               cur_lvl,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               ratio_ok,
  output logic [DIV_W-1:0]   cur_div,
  output logic [SRC_W-1:0]   cur_src,
  output logic               hit,
  output lvl_t               hit_lvl
);
  logic [DIV_W-1:0] div_f [NUM_LVL];
  logic [SRC_W-1:0] src_f [NUM_LVL];
  logic [NUM_LVL-1:0] match;

  // even levels take the upper half of their word, odd levels the lower half
  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    localparam int BASE = (g / 2) * 2 * HALF_W + (((g % 2) == 0) ? HALF_W : 0);
    assign div_f[g] = cfg[BASE + DIV_LSB +: DIV_W];
    assign src_f[g] = cfg[BASE + SRC_LSB +: SRC_W];
    assign match[g] = ratio_ok && (ratio == RATIO_W'(div_f[g]));
  end

  assign cur_div = div_f[cur_lvl];
  assign cur_src = src_f[cur_lvl];

  // lowest numbered matching level wins
  always_comb begin
    hit     = 1'b0;
    hit_lvl = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_lvl = lvl_t'(i);
      end
    end
  end
endmodule

// File: rtl/dvfs_settle_timer.sv
module dvfs_settle_timer #(
  parameter int SPAN = 80,
  localparam int CNT_W = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b1;
    if (start)              cnt_d = CNT_W'(SPAN - 1);
    else if (clear)         cnt_d = '0;
    else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
    else begin
      cnt_d  = cnt_q;
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
  import dvfs_pkg::*;
#(
  parameter int CYC_PER_MS  = 200000,
  parameter int DWELL_MS    = 20,
  parameter int FAST_MHZ    = 1000,
  parameter int RATE_W      = 12,
  parameter int RESET_LEVEL = 0,
  localparam int DWELL_CYC  = DWELL_MS * CYC_PER_MS,
  localparam int CFG_HALF_PAIR = 2 * HALF_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scale_en,
  input  logic [CFG_HALF_PAIR-1:0] cfg_lo_pair,
  input  logic [CFG_HALF_PAIR-1:0] cfg_hi_pair,
  input  logic [2:0]               static_div,
  input  logic [1:0]               static_src,
  input  logic                     req_valid,
  input  logic [RATE_W-1:0]        parent_mhz,
  input  logic [RATE_W-1:0]        target_mhz,
  output logic [1:0]               level,
  output logic [2:0]               act_div,
  output logic [1:0]               act_src,
  output logic                     busy,
  output logic                     done,
  output logic                     err
);
  seq_state_t state_q, state_d;
  lvl_t       lvl_q, lvl_d;
  logic       done_q, done_d, err_q, err_d;
  logic       rec_q, rec_d;
  logic       tmr_start, tmr_clear, tmr_expired;

  logic [RATE_W-1:0] ratio;
  logic              ratio_ok, hit, parent_fast, target_fast, accept;
  lvl_t              hit_lvl;
  logic [DIV_W-1:0]  tbl_div;
  logic [SRC_W-1:0]  tbl_src;

  assign ratio    = (target_mhz != '0) ? (parent_mhz / target_mhz) : '0;
  assign ratio_ok = (target_mhz != '0) && (ratio != '0);
  assign parent_fast = (int'(parent_mhz) >= FAST_MHZ);
  assign target_fast = (int'(target_mhz) >= FAST_MHZ);
  assign accept   = req_valid && (state_q == SEQ_IDLE);

  dvfs_level_table #(.NUM_LVL(4), .RATIO_W(RATE_W)) u_table (
    .cfg      ({cfg_hi_pair, cfg_lo_pair}),
    .cur_lvl  (lvl_q),
    .ratio    (ratio),
    .ratio_ok (ratio_ok),
    .cur_div  (tbl_div),
    .cur_src  (tbl_src),
    .hit      (hit),
    .hit_lvl  (hit_lvl)
  );

  dvfs_settle_timer #(.SPAN(DWELL_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (tmr_start),
    .clear   (tmr_clear),
    .expired (tmr_expired)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    lvl_d     = lvl_q;
    rec_d     = rec_q;
    done_d    = 1'b0;
    err_d     = 1'b0;
    tmr_start = 1'b0;
    tmr_clear = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (accept) begin
          if (!scale_en || !hit) begin
            err_d = 1'b1;
          end else if (hit_lvl == lvl_q) begin
            done_d = 1'b1;
          end else if (!parent_fast) begin
            lvl_d  = hit_lvl;
            done_d = 1'b1;
          end else begin
            unique case (hit_lvl)
              2'd1: begin
                lvl_d  = 2'd1;
                done_d = 1'b1;
                rec_d  = 1'b1;
                if (lvl_q == 2'd0) tmr_clear = 1'b1;
                else               tmr_start = 1'b1;
              end
              2'd0: begin
                if (!target_fast || (rec_q && tmr_expired)) begin
                  lvl_d     = 2'd0;
                  done_d    = 1'b1;
                  rec_d     = 1'b0;
                  tmr_clear = 1'b1;
                end else begin
                  lvl_d     = 2'd1;
                  rec_d     = 1'b0;
                  tmr_start = 1'b1;
                  state_d   = SEQ_DWELL;
                end
              end
              default: begin
                lvl_d     = hit_lvl;
                done_d    = 1'b1;
                rec_d     = 1'b0;
                tmr_clear = 1'b1;
              end
            endcase
          end
        end
      end
      SEQ_DWELL: begin
        if (tmr_expired) begin
          lvl_d   = 2'd0;
          done_d  = 1'b1;
          state_d = SEQ_IDLE;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      lvl_q   <= lvl_t'(RESET_LEVEL);
      rec_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      rec_q   <= rec_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign level   = lvl_q;
  assign act_div = scale_en ? tbl_div : static_div;
  assign act_src = scale_en ? tbl_src : static_src;
  assign busy    = (state_q == SEQ_DWELL);
  assign done    = done_q;
  assign err     = err_q;
endmodule

// File: rtl/dvfs_seq_chk.sv
module dvfs_seq_chk #(
  parameter int CYC_PER_MS = 200000,
  parameter int DWELL_MS   = 20,
  parameter int FAST_MHZ   = 1000,
  parameter int RATE_W     = 12,
  localparam int DWELL_CYC = DWELL_MS * CYC_PER_MS
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scale_en,
  input logic              req_valid,
  input logic [RATE_W-1:0] parent_mhz,
  input logic [1:0]        level,
  input logic              busy,
  input logic              done,
  input logic              err
);
  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_done_err_excl_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));

  assert_busy_at_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (level == 2'd1));

  assert_dwell_length_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == DWELL_CYC) && done && (level == 2'd0));

  assert_busy_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !err));

  assert_off_reject_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!scale_en && req_valid && !busy) |=> (err && (level == $past(level))));

  assert_slow_no_dwell_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !busy && (int'(parent_mhz) < FAST_MHZ)) |=> !busy);
endmodule

bind dvfs_seq dvfs_seq_chk #(
  .CYC_PER_MS (CYC_PER_MS),
  .DWELL_MS   (DWELL_MS),
  .FAST_MHZ   (FAST_MHZ),
  .RATE_W     (RATE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scale_en   (scale_en),
  .req_valid  (req_valid),
  .parent_mhz (parent_mhz),
  .level      (level),
  .busy       (busy),
  .done       (done),
  .err        (err)
);

// File: tb/dvfs_seq_tb.sv
module dvfs_seq_tb;
  localparam int CPM = 4;
  localparam int DMS = 20;
  localparam int N   = CPM * DMS;

  logic        clk, rst_n, scale_en, req_valid;
  logic [31:0] cfg_lo_pair, cfg_hi_pair;
  logic [2:0]  static_div;
  logic [1:0]  static_src;
  logic [11:0] parent_mhz, target_mhz;
  logic [1:0]  level, act_src;
  logic [2:0]  act_div;
  logic        busy, done, err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  dvfs_seq #(.CYC_PER_MS(CPM), .DWELL_MS(DMS), .FAST_MHZ(1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .scale_en(scale_en),
    .cfg_lo_pair(cfg_lo_pair), .cfg_hi_pair(cfg_hi_pair),
    .static_div(static_div), .static_src(static_src),
    .req_valid(req_valid), .parent_mhz(parent_mhz), .target_mhz(target_mhz),
    .level(level), .act_div(act_div), .act_src(act_src),
    .busy(busy), .done(done), .err(err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] enc(input int dv, input int sr);
    return {3'(dv), 1'b0, 1'b0, 2'(sr), 9'b0};
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
      summary();
    end
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  // Drive a request from the current negedge; hold until done/err.
  task automatic run_req(input int p, input int t, input int exp_lvl,
                         input bit exp_err, input int exp_wait, input string rq);
    int waited = 0;
    int nd = 0;
    int ne = 0;
    parent_mhz = 12'(p);
    target_mhz = 12'(t);
    req_valid  = 1'b1;
    while (!(done || err) && waited < N + 20) begin
      @(negedge clk);
      waited++;
      if (done) nd++;
      if (err)  ne++;
      if (waited == 1 && exp_wait > 1)
        chk(busy && level == 2'd1, rq, "dwell starts at level 1 busy", int'(level), 1);
    end
    req_valid = 1'b0;
    chk(waited == exp_wait, rq, "cycles to response", waited, exp_wait);
    chk(ne == int'(exp_err) && nd == int'(!exp_err), rq, "response kind err", ne, int'(exp_err));
    chk(int'(level) == exp_lvl, rq, "level", int'(level), exp_lvl);
    @(negedge clk);
    chk(!done && !err && !busy, rq, "single pulse", int'(done) + int'(err), 0);
  endtask

  task automatic t_reset();
    chk(level == 2'd0, "R1", "level", int'(level), 0);
    chk(!busy && !done && !err, "R1", "busy/done/err", int'(busy) + int'(done) + int'(err), 0);
    chk(act_div == 3'd1 && act_src == 2'd0, "R2", "level0 fields", int'(act_div), 1);
  endtask

  task automatic t_disabled();
    scale_en = 1'b0;
    @(negedge clk);
    chk(act_div == 3'd6 && act_src == 2'd3, "R3", "static div", int'(act_div), 6);
    run_req(1200, 600, 0, 1'b1, 1, "R3");
    scale_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_search_lookup();
    run_req(1200, 300, 2, 1'b0, 1, "R4");
    chk(act_div == 3'd4 && act_src == 2'd2, "R2", "level2 fields", int'(act_div), 4);
    run_req(1200, 250, 2, 1'b0, 1, "R6");
    run_req(1200, 100, 2, 1'b1, 1, "R5");
    run_req(1200, 0, 2, 1'b1, 1, "R5");
    run_req(500, 1000, 2, 1'b1, 1, "R5");
  endtask

  task automatic t_forced_dwell();
    run_req(1200, 1200, 0, 1'b0, N + 1, "R8");
    chk(act_div == 3'd1, "R8", "level0 div", int'(act_div), 1);
  endtask

  task automatic t_from_zero();
    run_req(1200, 600, 1, 1'b0, 1, "R10");
    chk(act_div == 3'd2 && act_src == 2'd1, "R2", "level1 fields", int'(act_div), 2);
    run_req(1200, 1200, 0, 1'b0, 1, "R10");
  endtask

  task automatic t_interval_edge();
    run_req(1200, 240, 3, 1'b0, 1, "R9");
    chk(act_div == 3'd5 && act_src == 2'd3, "R2", "level3 fields", int'(act_div), 5);
    run_req(1200, 600, 1, 1'b0, 1, "R9");
    idle(N - 3);
    run_req(1200, 1200, 0, 1'b0, N + 1, "R9");
    run_req(1200, 240, 3, 1'b0, 1, "R9");
    run_req(1200, 600, 1, 1'b0, 1, "R9");
    idle(N - 2);
    run_req(1200, 1200, 0, 1'b0, 1, "R9");
  endtask

  task automatic t_discard();
    run_req(1200, 240, 3, 1'b0, 1, "R11");
    run_req(800, 400, 1, 1'b0, 1, "R11");
    idle(N + 5);
    run_req(1200, 1200, 0, 1'b0, N + 1, "R11");
  endtask

  task automatic t_slow_target();
    run_req(1200, 300, 2, 1'b0, 1, "R12");
    run_req(1200, 900, 0, 1'b0, 1, "R12");
  endtask

  task automatic t_slow_parent();
    run_req(800, 160, 3, 1'b0, 1, "R7");
    run_req(800, 800, 0, 1'b0, 1, "R7");
  endtask

  task automatic t_first_match();
    cfg_hi_pair = {enc(2, 2), enc(2, 3)};
    @(negedge clk);
    run_req(1200, 600, 1, 1'b0, 1, "R4");
    chk(act_src == 2'd1, "R4", "first match source", int'(act_src), 1);
  endtask

  task automatic t_stall();
    run_req(1200, 300, 2, 1'b0, 1, "R13");
    run_req(1200, 1100, 0, 1'b0, N + 1, "R13");
    chk(done == 1'b0, "R14", "no extra done", int'(done), 0);
  endtask

  initial begin
    rst_n = 1'b0; scale_en = 1'b1; req_valid = 1'b0;
    cfg_lo_pair = {enc(1, 0), enc(2, 1)};
    cfg_hi_pair = {enc(4, 2), enc(5, 3)};
    static_div = 3'd6; static_src = 2'd3;
    parent_mhz = '0; target_mhz = '0;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_disabled();
    t_search_lookup();
    t_forced_dwell();
    t_from_zero();
    t_interval_edge();
    t_discard();
    t_slow_target();
    t_slow_parent();
    t_stall();
    t_first_match();
    summary();
  end
endmodule